// File: doc/BRIEF.md
# LCG Random Nibble Register

This block is a 4-bit register on a nibble-wide data bus whose content is pseudorandom. A 32-bit linear congruential generator sits behind it. Software reads the register to get a fresh nibble. Each read hands back the nibble that is held at that moment, and then moves the generator forward by one step. When the step ends, the new low four bits of the state become the visible value.

Writing to the register reseeds the generator. A value from 0 to 14 is copied into all eight nibbles of the state, which makes the sequence that follows repeatable. The value 15 instead loads a 32-bit entropy word supplied from outside, and reset does the same. A separate step strobe advances the generator without a bus read.

The multiply is done over several cycles, one slice of the operand per cycle. A counter holds requests that arrive during a step, so none is dropped.

Top module: `lcg_nibble_reg`

## Requirements
- R1: Each step replaces the 32-bit state X with (X × 0x41C64E6D + 0x6073) mod 2^32, and the visible nibble becomes bits 3:0 of the result.
- R2: A read at the register address returns the nibble held at that moment on `rdData` in the same cycle, then triggers exactly one step.
- R3: Writing a value v in the range 0 to 14 sets the state to v repeated in all eight nibbles (v=1 gives 0x11111111), so the visible nibble becomes v.
- R4: Writing 15 loads the state from `entropy`, so the visible nibble becomes entropy bits 3:0.
- R5: While `rst_n` is low, the state loads from `entropy` on each clock edge, and nothing is queued or in progress.
- R6: A one-cycle pulse on `stepReq` triggers exactly one step.
- R7: Requests that arrive while a step is running are counted and each is served later by one step. A read and a `stepReq` in the same cycle count as two. The count saturates at 2^QCNT_W-1.
- R8: A write to the register cancels the running step and every queued request. A `stepReq` in the same cycle as such a write is dropped.
- R9: When no read addresses the register, `rdData` is 0. Reads and writes at any other address neither step nor change the state.
- R10: A step accepted from idle at clock edge e0 updates the visible nibble at edge e0+STEPS-1, where STEPS = 32/CHUNK_W. Reads before that edge still return the old nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Bus address |
| wrData | input | 4 | Write data nibble |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 4 | Read data; the current nibble during a read at REG_ADDR, otherwise 0 |
| entropy | input | 32 | External entropy word used for reseeding |
| stepReq | input | 1 | Extra step strobe |

## Verification
The properties assume that `rdEn` and `wrEn` are never high in the same cycle. They also assume that the request count never reaches saturation during normal use. The bench keeps to both: it drives one bus strobe per cycle and never has more than three requests outstanding. The properties also expect `entropy` to be sampled on the write edge, so the bench changes it only between accesses. The multiply is checked against a direct one-line model of the formula. The model is updated only at points the bench chooses, after enough idle cycles for every queued step to complete.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  localparam int          STATE_W      = 32;
  localparam int          NIB_W        = 4;
  localparam int          NIB_REPS     = STATE_W / NIB_W;
  localparam logic [31:0] LCG_MUL      = 32'h41C6_4E6D;
  localparam logic [31:0] LCG_INC      = 32'h0000_6073;
  localparam logic [3:0]  ENTROPY_CODE = 4'hF;

  typedef struct packed {
    logic first;    // step starts this cycle
    logic work;     // a multiply slice is processed this cycle
    logic last;     // final slice, commit the new state
    logic loadRep;  // reseed with replicated nibble
    logic loadEnt;  // reseed from entropy word
  } lcgStrb_t;
endpackage

// File: rtl/lcg_ctrl.sv
module lcg_ctrl
  import lcg_pkg::*;
#(
  parameter int STEPS  = 4,
  parameter int IDX_W  = 2,
  parameter int QCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdHit,
  input  logic              wrHit,
  input  logic [3:0]        wrData,
  input  logic              stepReq,
  output lcgStrb_t          strb,
  output logic [IDX_W-1:0]  chunkIdx,
  output logic              busy,
  output logic [QCNT_W-1:0] pendCnt
);
  localparam logic [QCNT_W-1:0] PEND_MAX = '1;
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(STEPS - 1);

  logic [1:0]      reqCnt;
  logic            start;
  logic [QCNT_W:0] pendSum;
  logic [QCNT_W-1:0] pendNext;

  always_comb begin
    reqCnt   = wrHit ? 2'd0 : ({1'b0, rdHit} + {1'b0, stepReq});
    start    = !wrHit && !busy && ((pendCnt != '0) || (reqCnt != 2'd0));
    pendSum  = {1'b0, pendCnt} + (QCNT_W+1)'(reqCnt) - (QCNT_W+1)'(start);
    pendNext = (pendSum > {1'b0, PEND_MAX}) ? PEND_MAX : pendSum[QCNT_W-1:0];

    strb         = '0;
    strb.loadEnt = wrHit && (wrData == ENTROPY_CODE);
    strb.loadRep = wrHit && (wrData != ENTROPY_CODE);
    strb.first   = start;
    strb.work    = start || (busy && !wrHit);
    strb.last    = (start && (STEPS == 1)) || (busy && !wrHit && (chunkIdx == IDX_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wrHit) begin
      busy     <= 1'b0;
      chunkIdx <= '0;
      pendCnt  <= '0;
    end else begin
      pendCnt <= pendNext;
      if (start) begin
        busy     <= (STEPS > 1);
        chunkIdx <= IDX_W'(1);
      end else if (busy) begin
        if (strb.last) busy <= 1'b0;
        chunkIdx <= chunkIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcg_datapath.sv
module lcg_datapath
  import lcg_pkg::*;
#(
  parameter int CHUNK_W = 8,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  lcgStrb_t           strb,
  input  logic [IDX_W-1:0]   chunkIdx,
  input  logic [3:0]         wrData,
  input  logic [STATE_W-1:0] entropy,
  output logic [STATE_W-1:0] lcgState
);
  logic [STATE_W-1:0] acc, opnd, src, base, partial, sum;
  logic [CHUNK_W-1:0] slice;
  logic [IDX_W-1:0]   idxEff;
  int                 shAmt;

  always_comb begin
    idxEff  = strb.first ? '0 : chunkIdx;
    src     = strb.first ? lcgState : opnd;
    base    = strb.first ? '0 : acc;
    shAmt   = int'(idxEff) * CHUNK_W;
    slice   = src[shAmt +: CHUNK_W];
    partial = (LCG_MUL * STATE_W'(slice)) << shAmt;
    sum     = base + partial;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcgState <= entropy;
      acc      <= '0;
      opnd     <= '0;
    end else if (strb.loadEnt) begin
      lcgState <= entropy;
    end else if (strb.loadRep) begin
      lcgState <= {NIB_REPS{wrData}};
    end else if (strb.work) begin
      if (strb.first) opnd <= lcgState;
      if (strb.last) lcgState <= sum + LCG_INC;
      else           acc      <= sum;
    end
  end
endmodule

// File: rtl/lcg_nibble_reg.sv
module lcg_nibble_reg
  import lcg_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFF,
  parameter int              CHUNK_W  = 8,
  parameter int              QCNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [3:0]        rdData,
  input  logic [31:0]       entropy,
  input  logic              stepReq
);
  localparam int STEPS = STATE_W / CHUNK_W;
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  lcgStrb_t           strb;
  logic [IDX_W-1:0]   chunkIdx;
  logic               busy;
  logic [QCNT_W-1:0]  pendCnt;
  logic [STATE_W-1:0] lcgState;
  logic               rdHit, wrHit;

  assign rdHit  = rdEn && (addr == REG_ADDR);
  assign wrHit  = wrEn && (addr == REG_ADDR);
  assign rdData = rdHit ? lcgState[3:0] : 4'h0;

  lcg_ctrl #(.STEPS(STEPS), .IDX_W(IDX_W), .QCNT_W(QCNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdHit(rdHit), .wrHit(wrHit), .wrData(wrData),
    .stepReq(stepReq), .strb(strb), .chunkIdx(chunkIdx), .busy(busy), .pendCnt(pendCnt)
  );

  lcg_datapath #(.CHUNK_W(CHUNK_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .chunkIdx(chunkIdx), .wrData(wrData),
    .entropy(entropy), .lcgState(lcgState)
  );
endmodule

// File: rtl/lcg_nibble_reg_chk.sv
module lcg_nibble_reg_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFF,
  parameter int                QCNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [3:0]        wrData,
  input logic              rdEn,
  input logic              stepReq,
  input logic [31:0]       entropy,
  input logic [31:0]       lcgState,
  input logic              busy,
  input logic [QCNT_W-1:0] pendCnt
);
  localparam logic [QCNT_W-1:0] PEND_MAX = '1;
  logic wrHitC, rdHitC;
  assign wrHitC = wrEn && (addr == REG_ADDR);
  assign rdHitC = rdEn && (addr == REG_ADDR);

  a_r3_rep_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (wrHitC && wrData != 4'hF) |=> (lcgState == {8{$past(wrData)}}));

  a_r4_ent_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (wrHitC && wrData == 4'hF) |=> (lcgState == $past(entropy)));

  a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    wrHitC |=> (!busy && pendCnt == '0));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (pendCnt == PEND_MAX && !wrHitC) |=> (pendCnt >= PEND_MAX - 1'b1));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pendCnt == '0 && !wrHitC && !rdHitC && !stepReq) |=> $stable(lcgState));
endmodule

bind lcg_nibble_reg lcg_nibble_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .QCNT_W(QCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
  .stepReq(stepReq), .entropy(entropy), .lcgState(lcgState), .busy(busy), .pendCnt(pendCnt)
);

// File: tb/tb_lcg_nibble_reg.sv
`timescale 1ns/1ps
module tb_lcg_nibble_reg;
  localparam int STEPS = 4;
  localparam logic [7:0] RA = 8'hFF;
  localparam logic [3:0] SEEDS [8] = '{4'd0, 4'd1, 4'd7, 4'd10, 4'd14, 4'd3, 4'd9, 4'd15};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wrEn = 1'b0, rdEn = 1'b0, stepReq = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [3:0] wrData = 4'h0, rdData;
  logic [31:0] entropy = 32'h1234_ABC9;
  logic [31:0] model;
  int nChecks = 0, nFails = 0;

  lcg_nibble_reg dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .entropy(entropy), .stepReq(stepReq)
  );

  function automatic logic [31:0] lcgNext(input logic [31:0] x);
    lcgNext = x * 32'h41C6_4E6D + 32'h0000_6073;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; the read is taken at the next rising edge
  task automatic readExpect(input string tag, input logic [7:0] a, input logic [3:0] exp);
    addr = a; rdEn = 1'b1;
    #1 chk(tag, rdData, exp);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [3:0] v, input logic withStep);
    addr = a; wrData = v; wrEn = 1'b1; stepReq = withStep;
    @(negedge clk);
    wrEn = 1'b0; stepReq = 1'b0;
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    #1 chk("R9 idle rdData", rdData, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    model = entropy;
    // R5: reset seed from entropy
    readExpect("R5 reset seed", RA, model[3:0]);
    model = lcgNext(model); idle(STEPS);
    readExpect("R2 read after step", RA, model[3:0]);
    model = lcgNext(model); idle(STEPS);

    // table of seeds: R3 / R4 then R1 sequence
    for (int i = 0; i < 8; i++) begin
      entropy = 32'h9E37_79B9 ^ (i * 32'h0101_1013);
      writeReg(RA, SEEDS[i], 1'b0);
      model = (SEEDS[i] == 4'hF) ? entropy : {8{SEEDS[i]}};
      for (int k = 0; k < 3; k++) begin
        readExpect((k == 0) ? ((SEEDS[i] == 4'hF) ? "R4 entropy seed" : "R3 replicated seed")
                            : "R1 lcg step", RA, model[3:0]);
        model = lcgNext(model); idle(STEPS);
      end
    end

    // R6: external step strobe
    stepReq = 1'b1; @(negedge clk); stepReq = 1'b0;
    model = lcgNext(model); idle(STEPS);
    readExpect("R6 step strobe", RA, model[3:0]);
    model = lcgNext(model); idle(STEPS);

    // R7: read while busy is queued
    readExpect("R7 first read", RA, model[3:0]);
    readExpect("R7 read while busy", RA, model[3:0]);
    model = lcgNext(lcgNext(model)); idle(3 * STEPS);
    readExpect("R7 two queued steps", RA, model[3:0]);
    model = lcgNext(model); idle(STEPS);
    // R7: read and step strobe in the same cycle
    addr = RA; rdEn = 1'b1; stepReq = 1'b1;
    #1 chk("R7 dual request read", rdData, model[3:0]);
    @(negedge clk); rdEn = 1'b0; stepReq = 1'b0;
    model = lcgNext(lcgNext(model)); idle(3 * STEPS);
    readExpect("R7 dual request result", RA, model[3:0]);
    model = lcgNext(model); idle(STEPS);

    // R10: latency of one step
    readExpect("R10 start", RA, model[3:0]);
    idle(2);
    readExpect("R10 before commit", RA, model[3:0]);
    readExpect("R10 after commit", RA, lcgNext(model) & 32'hF);
    model = lcgNext(lcgNext(lcgNext(model))); idle(3 * STEPS + 2);
    readExpect("R10 queued result", RA, model[3:0]);
    model = lcgNext(model); idle(STEPS);

    // R8: write cancels running step and drops a same-cycle step strobe
    readExpect("R8 start step", RA, model[3:0]);
    writeReg(RA, 4'h5, 1'b1);
    model = 32'h5555_5555; idle(3 * STEPS);
    readExpect("R8 cancel", RA, 4'h5);
    model = lcgNext(model); idle(STEPS);
    readExpect("R8 one step only", RA, model[3:0]);
    model = lcgNext(model); idle(STEPS);

    // R9: other addresses
    readExpect("R9 foreign read data", 8'h00, 4'h0);
    idle(STEPS);
    writeReg(8'h3C, 4'h3, 1'b0);
    idle(STEPS);
    readExpect("R9 state untouched", RA, model[3:0]);
    model = lcgNext(model); idle(STEPS);

    // R5: reset mid-run reseeds from entropy
    entropy = 32'hCAFE_F00E;
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
    model = entropy;
    readExpect("R5 second reset", RA, model[3:0]);
    idle(STEPS);

    finishRun();
  end
endmodule